// File: doc/BRIEF.md
# Banked System Interrupt Router

This block sits between the peripheral interrupt lines of a chip and the core's interrupt priority controller. It samples two banks of 32 level-sensitive request lines into read-only status registers. A per-bank mask register gates these samples. Every line that is both sampled high and enabled is steered to one of nine core priority outputs. Level 7 is the most urgent and level 15 the least. A 4-bit routing field owned by each line selects the output.

Software programs the block through a small register bus that completes each access one cycle after it is presented. The bus accepts 16-bit and 32-bit accesses. It reports size violations and accesses to empty offsets through an error code, and the size violation takes precedence. The register set holds three 16-bit control words, a mask, a status and a wake word for each bank, and the routing registers. The control and wake words only store what is written to them.

Top module: `irq_router_top`

## Requirements
- R1: After reset, mask and status read 0, wake words read 0xFFFFFFFF, routing registers 0..7 read 0x10000000, 0x33322221, 0x66655444, 0x00000000, 0x32222220, 0x44433333, 0x00444664, 0x00000000, and `core_irq` and `cfg_err` are 0.
- R2: A line is pending only when its status bit and its mask bit are both 1. A line that is sampled high but masked drives no output.
- R3: Line n of bank b takes its field from routing register b*4 + n/8, bits (n mod 8)*4 +: 4. A field value v drives `core_irq[v]`, which is core level 7+v.
- R4: An output stays asserted while at least one pending line is routed to it, and it drops only when the last such line clears.
- R5: Status words reflect the input levels sampled on the previous clock. Bus writes to them are discarded.
- R6: `bus_size` encodes 0 = byte, 1 = half, 2 = word, 3 = reserved. A byte or reserved access returns error code 1 and changes nothing. An aligned access to an offset with no register returns error code 2 and read data 0. A bad size at an empty offset reports code 1. A good access returns code 0.
- R7: A half-word write replaces only bits 15:0 of the target. A half-word read returns bits 15:0 with the upper half zero.
- R8: Control words at offsets 0x00, 0x04 and 0x08 keep 16 bits, and their upper bits read as 0. Wake words at 0x30 and 0x34 store all 32 bits. Mask words sit at 0x10 and 0x14, status words at 0x20 and 0x24, and routing registers at 0x40 + 4*k.
- R9: A pending line whose field is above 8 drives no output and sets `cfg_err`. Once set, `cfg_err` stays at 1 until reset.
- R10: `core_irq` changes on the second clock edge after an input change. After a register write, it changes on the edge following the one that completes the write.
- R11: `bus_ack` is high for exactly the cycle after each cycle in which `bus_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Peripheral request levels; bits 31:0 are bank 0, bits 63:32 are bank 1 |
| bus_valid | input | 1 | Access request, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Access completed (one cycle after request) |
| bus_rdata | output | 32 | Read data, 0 for writes and errors |
| bus_err_code | output | 2 | 0 ok, 1 bad size, 2 no register |
| core_irq | output | 9 | Bit v requests core level 7+v |
| cfg_err | output | 1 | Sticky flag: a pending line had a field above 8 |

## Verification
Two situations are hard to reach from the ports: several lines sharing one output while only some of them drop, and a pending line whose routing field is out of range. The stimulus reaches them by rewriting a routing register while its lines are held high and enabled. It then releases the lines one at a time. Each step checks that the output holds or falls as expected and that the error flag stays set after the field is repaired. Reset values of the routing registers are mixed, so the first routing checks show that bank 1 decodes its own registers rather than bank 0's.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  // access size codes
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // error codes (size error outranks missing register)
  localparam logic [1:0] ERR_NONE = 2'd0;
  localparam logic [1:0] ERR_SIZE = 2'd1;
  localparam logic [1:0] ERR_MAP  = 2'd2;

  // word-index bases of each register group
  localparam int CTRL_W0  = 0;
  localparam int NUM_CTRL = 3;
  localparam int CTRL_BITS = 16;
  localparam int MASK_W0  = 4;
  localparam int STAT_W0  = 8;
  localparam int WAKE_W0  = 12;
  localparam int ASGN_W0  = 16;

  typedef enum logic [2:0] {
    K_NONE, K_CTRL, K_MASK, K_STAT, K_WAKE, K_ASGN
  } reg_kind_e;
endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter int NB      = 2,
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 4,
  parameter int ADDR_W  = 8,
  parameter logic [NB*DATA_W*FIELD_W-1:0] ASGN_RST = {
    32'h00000000, 32'h00444664, 32'h44433333, 32'h32222220,
    32'h00000000, 32'h66655444, 32'h33322221, 32'h10000000}
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NB*DATA_W-1:0]         irq_in,
  input  logic                         bus_valid,
  input  logic                         bus_write,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [1:0]                   bus_size,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic                         bus_ack,
  output logic [DATA_W-1:0]            bus_rdata,
  output logic [1:0]                   bus_err_code,
  output logic [NB*DATA_W-1:0]         mask_o,
  output logic [NB*DATA_W-1:0]         stat_o,
  output logic [NB*DATA_W*FIELD_W-1:0] asgn_o
);
  localparam int NA   = NB * FIELD_W;   // routing registers
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] ctrl_r [NUM_CTRL];
  logic [DATA_W-1:0] mask_r [NB];
  logic [DATA_W-1:0] stat_r [NB];
  logic [DATA_W-1:0] wake_r [NB];
  logic [DATA_W-1:0] asgn_r [NA];

  reg_kind_e         kind;
  int                idx;
  int                word;
  logic              size_ok;
  logic [DATA_W-1:0] cur_val;
  logic [DATA_W-1:0] new_val;

  // address decode
  always_comb begin
    kind = K_NONE;
    idx  = 0;
    word = int'(bus_addr[ADDR_W-1:2]);
    if (bus_addr[1:0] == 2'b00) begin
      if (word >= CTRL_W0 && word < CTRL_W0 + NUM_CTRL) begin
        kind = K_CTRL; idx = word - CTRL_W0;
      end else if (word >= MASK_W0 && word < MASK_W0 + NB) begin
        kind = K_MASK; idx = word - MASK_W0;
      end else if (word >= STAT_W0 && word < STAT_W0 + NB) begin
        kind = K_STAT; idx = word - STAT_W0;
      end else if (word >= WAKE_W0 && word < WAKE_W0 + NB) begin
        kind = K_WAKE; idx = word - WAKE_W0;
      end else if (word >= ASGN_W0 && word < ASGN_W0 + NA) begin
        kind = K_ASGN; idx = word - ASGN_W0;
      end
    end
  end

  always_comb begin
    size_ok = (bus_size == SZ_HALF) || (bus_size == SZ_WORD);
    unique case (kind)
      K_CTRL:  cur_val = ctrl_r[idx];
      K_MASK:  cur_val = mask_r[idx];
      K_STAT:  cur_val = stat_r[idx];
      K_WAKE:  cur_val = wake_r[idx];
      K_ASGN:  cur_val = asgn_r[idx];
      default: cur_val = '0;
    endcase
    if (bus_size == SZ_HALF) new_val = {cur_val[DATA_W-1:HALF], bus_wdata[HALF-1:0]};
    else                     new_val = bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CTRL; c++) ctrl_r[c] <= '0;
      for (int b = 0; b < NB; b++) begin
        mask_r[b] <= '0;
        stat_r[b] <= '0;
        wake_r[b] <= '1;
      end
      for (int a = 0; a < NA; a++) asgn_r[a] <= ASGN_RST[a*DATA_W +: DATA_W];
      bus_ack      <= 1'b0;
      bus_rdata    <= '0;
      bus_err_code <= ERR_NONE;
    end else begin
      for (int b = 0; b < NB; b++) stat_r[b] <= irq_in[b*DATA_W +: DATA_W];
      bus_ack <= bus_valid;
      if (bus_valid) begin
        bus_rdata <= '0;
        if (!size_ok) begin
          bus_err_code <= ERR_SIZE;
        end else if (kind == K_NONE) begin
          bus_err_code <= ERR_MAP;
        end else begin
          bus_err_code <= ERR_NONE;
          if (bus_write) begin
            unique case (kind)
              K_CTRL:  ctrl_r[idx] <= {{(DATA_W-CTRL_BITS){1'b0}}, new_val[CTRL_BITS-1:0]};
              K_MASK:  mask_r[idx] <= new_val;
              K_WAKE:  wake_r[idx] <= new_val;
              K_ASGN:  asgn_r[idx] <= new_val;
              default: ;  // status is read-only
            endcase
          end else if (bus_size == SZ_HALF) begin
            bus_rdata <= {{HALF{1'b0}}, cur_val[HALF-1:0]};
          end else begin
            bus_rdata <= cur_val;
          end
        end
      end
    end
  end

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bank_out
      assign mask_o[b*DATA_W +: DATA_W] = mask_r[b];
      assign stat_o[b*DATA_W +: DATA_W] = stat_r[b];
    end
    for (genvar a = 0; a < NA; a++) begin : g_asgn_out
      assign asgn_o[a*DATA_W +: DATA_W] = asgn_r[a];
    end
  endgenerate
endmodule

// File: rtl/irq_router_bank.sv
module irq_router_bank #(
  parameter int LINES      = 32,
  parameter int FIELD_W    = 4,
  parameter int NUM_LEVELS = 9
) (
  input  logic [LINES-1:0]         pend,
  input  logic [LINES*FIELD_W-1:0] fields,
  output logic [NUM_LEVELS-1:0]    hit,
  output logic                     bad
);
  // fields are packed line by line: line n at n*FIELD_W, which places it
  // in routing register n/8 at bit (n mod 8)*4 for 32-bit registers
  always_comb begin
    hit = '0;
    bad = 1'b0;
    for (int n = 0; n < LINES; n++) begin
      if (pend[n]) begin
        if (int'(fields[n*FIELD_W +: FIELD_W]) < NUM_LEVELS)
          hit[int'(fields[n*FIELD_W +: FIELD_W])] = 1'b1;
        else
          bad = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
  import irq_router_pkg::*;
#(
  parameter int NB         = 2,
  parameter int DATA_W     = 32,
  parameter int FIELD_W    = 4,
  parameter int ADDR_W     = 8,
  parameter int NUM_LEVELS = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NB*DATA_W-1:0]  irq_in,
  input  logic                  bus_valid,
  input  logic                  bus_write,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [1:0]            bus_size,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic                  bus_ack,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [1:0]            bus_err_code,
  output logic [NUM_LEVELS-1:0] core_irq,
  output logic                  cfg_err
);
  localparam int LINES  = NB * DATA_W;
  localparam int BANK_F = DATA_W * FIELD_W;

  logic [LINES-1:0]         mask_all;
  logic [LINES-1:0]         stat_all;
  logic [LINES*FIELD_W-1:0] asgn_all;
  logic [LINES-1:0]         pend_all;
  logic [NUM_LEVELS-1:0]    hit_b [NB];
  logic [NB-1:0]            bad_b;
  logic [NUM_LEVELS-1:0]    hit_all;

  irq_router_regs #(
    .NB(NB), .DATA_W(DATA_W), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err_code(bus_err_code),
    .mask_o(mask_all), .stat_o(stat_all), .asgn_o(asgn_all)
  );

  assign pend_all = stat_all & mask_all;

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bank
      irq_router_bank #(
        .LINES(DATA_W), .FIELD_W(FIELD_W), .NUM_LEVELS(NUM_LEVELS)
      ) u_bank (
        .pend  (pend_all[b*DATA_W +: DATA_W]),
        .fields(asgn_all[b*BANK_F +: BANK_F]),
        .hit   (hit_b[b]),
        .bad   (bad_b[b])
      );
    end
  endgenerate

  always_comb begin
    hit_all = '0;
    for (int b = 0; b < NB; b++) hit_all = hit_all | hit_b[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      core_irq <= '0;
      cfg_err  <= 1'b0;
    end else begin
      core_irq <= hit_all;
      cfg_err  <= cfg_err | (|bad_b);
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int LINES      = 64,
  parameter int NUM_LEVELS = 9
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_valid,
  input logic [1:0]            bus_size,
  input logic                  bus_ack,
  input logic [1:0]            bus_err_code,
  input logic [LINES-1:0]      irq_in,
  input logic [LINES-1:0]      stat,
  input logic [LINES-1:0]      pend,
  input logic [NUM_LEVELS-1:0] core_irq,
  input logic                  cfg_err
);
  // R5
  status_track_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> stat == $past(irq_in));

  // R2
  idle_out_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(|pend)) |-> core_irq == '0);

  // R9
  sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);

  // R11
  ack_follow_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid |=> bus_ack);

  // R11
  no_spurious_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> !bus_ack);

  // R6
  size_err_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !(bus_size == 2'd1 || bus_size == 2'd2)) |=> bus_err_code == 2'd1);
endmodule

bind irq_router_top irq_router_chk #(
  .LINES(NB*DATA_W), .NUM_LEVELS(NUM_LEVELS)
) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_size(bus_size),
  .bus_ack(bus_ack), .bus_err_code(bus_err_code), .irq_in(irq_in),
  .stat(stat_all), .pend(pend_all), .core_irq(core_irq), .cfg_err(cfg_err)
);

// File: tb/irq_router_top_tb.sv
module irq_router_top_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] data;
    logic [1:0]  err;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_in = '0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic        bus_ack;
  logic [31:0] bus_rdata;
  logic [1:0]  bus_err_code;
  logic [8:0]  core_irq;
  logic        cfg_err;

  int   n_checks = 0;
  int   n_errors = 0;
  exp_t sb_q[$];
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_router_top u_dut (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err_code(bus_err_code),
    .core_irq(core_irq), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: queue the expected response, then present one access
  task automatic bus(input logic wr, input logic [7:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, input logic [31:0] ed,
                     input logic [1:0] ee, input string req);
    exp_t e;
    @(negedge clk);
    e.data = ed; e.err = ee; e.req = req;
    sb_q.push_back(e);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic wr32(input logic [7:0] a, input logic [31:0] d, input string req);
    bus(1'b1, a, 2'd2, d, 32'h0, 2'd0, req);
  endtask

  task automatic rd32(input logic [7:0] a, input logic [31:0] ed, input string req);
    bus(1'b0, a, 2'd2, 32'h0, ed, 2'd0, req);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  // monitor: pop and compare each completed access
  always @(negedge clk) begin
    if (!rst && bus_ack) begin
      if (sb_q.size() == 0) begin
        n_checks++; n_errors++;
        $display("FAIL R11: actual=unexpected ack expected=no ack");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk({e.req, " data"}, bus_rdata, e.data);
        chk({e.req, " err"}, {30'd0, bus_err_code}, {30'd0, e.err});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 core_irq", {23'd0, core_irq}, 32'h0);
    chk("R1 cfg_err", {31'd0, cfg_err}, 32'h0);
    rd32(8'h10, 32'h0, "R1 mask0");
    rd32(8'h24, 32'h0, "R1 status1");
    rd32(8'h34, 32'hFFFFFFFF, "R1 wake1");
    rd32(8'h40, 32'h10000000, "R1 route0");
    rd32(8'h44, 32'h33322221, "R1 route1");
    rd32(8'h54, 32'h44433333, "R1 route5");

    // R2 sampled but masked line drives nothing
    irq_in[0] = 1'b1;
    settle();
    chk("R2 masked", {23'd0, core_irq}, 32'h0);
    rd32(8'h20, 32'h1, "R5 status0 level");

    // R10 output one edge after the write edge; R3 field 0 -> level 7
    wr32(8'h10, 32'h1, "R2 mask0 write");
    chk("R10 not yet", {23'd0, core_irq}, 32'h0);
    @(negedge clk);
    chk("R3 line0 to bit0", {23'd0, core_irq}, 32'h001);

    // R3 line 7 has field 1
    irq_in[7] = 1'b1;
    wr32(8'h10, 32'h81, "R3 mask0 write");
    @(negedge clk);
    chk("R3 line7 to bit1", {23'd0, core_irq}, 32'h003);

    // R3 bank 1 line 7 uses route4 field 3
    irq_in[39] = 1'b1;
    wr32(8'h14, 32'h80, "R3 mask1 write");
    @(negedge clk);
    chk("R3 bank1 line7 to bit3", {23'd0, core_irq}, 32'h00B);

    // R3 field value 8 -> level 15
    wr32(8'h40, 32'h10000008, "R3 route0 write");
    @(negedge clk);
    chk("R3 field8 to bit8", {23'd0, core_irq}, 32'h10A);

    // R4 two lines on one output
    irq_in[9] = 1'b1; irq_in[10] = 1'b1;
    wr32(8'h10, 32'h681, "R4 mask0 write");
    @(negedge clk);
    chk("R4 both", {23'd0, core_irq}, 32'h10E);
    irq_in[9] = 1'b0;
    settle();
    chk("R4 one left", {23'd0, core_irq}, 32'h10E);
    irq_in[10] = 1'b0;
    settle();
    chk("R4 none left", {23'd0, core_irq}, 32'h10A);

    // R9 out-of-range field
    wr32(8'h40, 32'h1000000F, "R9 route0 write");
    @(negedge clk);
    chk("R9 ignored", {23'd0, core_irq}, 32'h00A);
    chk("R9 flag set", {31'd0, cfg_err}, 32'h1);
    wr32(8'h40, 32'h10000000, "R9 route0 repair");
    @(negedge clk);
    chk("R9 repaired route", {23'd0, core_irq}, 32'h00B);
    chk("R9 flag sticky", {31'd0, cfg_err}, 32'h1);

    // R5 status write discarded
    wr32(8'h20, 32'hFFFFFFFF, "R5 status write");
    rd32(8'h20, 32'h81, "R5 status unchanged");

    // R6 size and map errors
    bus(1'b1, 8'h10, 2'd0, 32'hFFFFFFFF, 32'h0, 2'd1, "R6 byte write");
    rd32(8'h10, 32'h681, "R6 mask kept");
    bus(1'b1, 8'h10, 2'd3, 32'h0, 32'h0, 2'd1, "R6 reserved size");
    bus(1'b0, 8'h7C, 2'd2, 32'h0, 32'h0, 2'd2, "R6 unmapped read");
    bus(1'b0, 8'h7C, 2'd0, 32'h0, 32'h0, 2'd1, "R6 size outranks map");
    bus(1'b0, 8'h12, 2'd2, 32'h0, 32'h0, 2'd2, "R6 misaligned");

    // R7 half-word access
    bus(1'b1, 8'h30, 2'd1, 32'h5555ABCD, 32'h0, 2'd0, "R7 half write");
    rd32(8'h30, 32'hFFFFABCD, "R7 upper kept");
    bus(1'b0, 8'h30, 2'd1, 32'h0, 32'h0000ABCD, 2'd0, "R7 half read");

    // R8 control and wake storage
    wr32(8'h04, 32'h12345678, "R8 ctrl1 write");
    rd32(8'h04, 32'h00005678, "R8 ctrl1 16 bits");
    wr32(8'h34, 32'hA5A5_0F0F, "R8 wake1 write");
    rd32(8'h34, 32'hA5A50F0F, "R8 wake1 stored");

    // R10 input release reaches output on second edge
    @(negedge clk);
    irq_in = '0;
    @(negedge clk);
    chk("R10 one edge", {23'd0, core_irq}, 32'h00B);
    @(negedge clk);
    chk("R10 two edges", {23'd0, core_irq}, 32'h0);

    repeat (3) @(negedge clk);
    chk("R11 queue drained", sb_q.size(), 32'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule